// File: doc/BRIEF.md
# Register-Programmed Serial Flash Master

This block is a single-lane SPI master for a serial flash device. A processor controls it through a small 32-bit register bus. Before each transfer, software sets up a header: an instruction byte, up to three address bytes, and a count register that says how many of each to send. Software then sets a start bit. After the header the block enters a payload phase. In the write direction it shifts out bytes that software has placed in a transmit FIFO. In the read direction it clocks in bytes and places them in a receive FIFO.

The block owns chip-select, serial clock generation and bit serialization. The bus runs in mode 0: the clock idles low and data is sampled on the rising edge. Bytes go out most significant bit first. The serial clock half-period is a fixed number of system clocks set by a parameter.

Starting and stopping a transfer are handshakes. A requested stop takes effect only once the transmit FIFO has drained, and the start bit stays set until the transfer has really ended. A flush bit empties both FIFOs and clears itself. A read-mode register is provided as plain storage only.

Top module: `sflash_master`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0x52: bit1 transfer-ready = 1, bit4 receive-empty = 1, bit6 transmit-empty = 1, bit7 transmit-full = 0, bit0 chip-select enable = 0. The chip-select output is high and the serial clock is low.
- R2: The following registers read back exactly what was written:
  - instruction (0x10, bits [7:0])
  - address (0x14, 32 bits)
  - read-mode (0x18, 32 bits)
  - header-count (0x1C, bits [7:0])
  - data-in-count (0x20, 32 bits)
- R3: Writing 1 to configuration (0x04) bit15 while idle starts a transfer. The header goes out first:
  - header-count[3:0] copies of the instruction byte;
  - then min(header-count[7:4], 3) address bytes, taken from the low bytes of the address register, most significant byte first.
  - Each byte is sent MSB first, in SPI mode 0.
- R4: When configuration bit13 is 1 (write direction), the bytes from the transmit FIFO follow the header on the serial output, in the order they were written to data-out (0x08).
- R5: Setting configuration bit14 ends the transfer only after the transmit FIFO is empty. Configuration bit15 reads 1 until the transfer has ended, then reads 0.
- R6: When bit13 is 0 (read direction) and data-in-count is N > 0, exactly N bytes are captured into the receive FIFO, and the transfer then ends without any stop request.
- R7: With a data-in-count of 0, reading continues until a stop is requested. While the receive FIFO holds 8 bytes, clocking pauses and no byte is lost.
- R8: A read of data-in (0x0C) returns the oldest received byte and removes it. A read of data-in while the receive FIFO is empty returns 0.
- R9: The transmit FIFO holds 8 bytes. Control bit7 reads 1 when it is full, and writes to data-out made while it is full are dropped.
- R10: Writing 1 to configuration bit9 empties both FIFOs. Bit9 reads 1 in the cycle after that write and then clears by itself.
- R11: Control bit1 reads 0 while a transfer is running or a flush is pending.
- R12: The chip-select output goes low only while control bit0 is 1 and a transfer is running. The serial clock stays low while no transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regEn | input | 1 | Register access strobe, one cycle per access |
| regWe | input | 1 | 1 = write access, 0 = read access |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle regEn is high |
| spiCsN | output | 1 | Flash chip-select, active low |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
If the header byte index or the address-byte selection goes wrong, the serial stream shows a wrong or missing byte within the first few bytes after chip-select falls. The bench's model of the flash exposes this as soon as the transfer ends.

A wrong FIFO pointer or count shows up at the register bus: the empty or full flags disagree with the number of bytes pushed, or bytes come back out of order on the next data-in read.

A sequencer that ends too early or too late shows up in two ways. The start bit clears while payload bytes are still unsent, or a counted read delivers the wrong number of bytes. A chip-select misdriven against its enable bit is caught in the very clock it happens.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_CONF  = 8'h04;
  localparam logic [7:0] OFF_DOUT  = 8'h08;
  localparam logic [7:0] OFF_DIN   = 8'h0C;
  localparam logic [7:0] OFF_INSTR = 8'h10;
  localparam logic [7:0] OFF_ADDR  = 8'h14;
  localparam logic [7:0] OFF_MODE  = 8'h18;
  localparam logic [7:0] OFF_HDR   = 8'h1C;
  localparam logic [7:0] OFF_DCNT  = 8'h20;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_FIN
  } seqState_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic pushTx;   // data-out write into transmit FIFO
    logic popRx;    // data-in read from receive FIFO
    logic flush;    // empty both FIFOs
    logic loadLit;  // shift a byte supplied by the sequencer
    logic loadFifo; // shift the transmit FIFO head
    logic capture;  // store the byte shifted in
  } dpCmd_t;

endpackage

// File: rtl/sflash_fifo.sv
module sflash_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             clear,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] LAST = (AW + 1)'(DEPTH - 1);
  localparam logic [AW:0] CAP  = (AW + 1)'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    rdPtr, wrPtr;
  logic [AW:0]      count;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CAP);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = store[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !clear) store[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= ({1'b0, wrPtr} == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= ({1'b0, rdPtr} == LAST) ? '0 : rdPtr + 1'b1;
      count <= count + (AW + 1)'(doPush) - (AW + 1)'(doPop);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !clear) |=> full);

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CAP);

endmodule

// File: rtl/sflash_dp.sv
module sflash_dp
  import sflash_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int SCK_HALF   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic [7:0] txData,
  input  logic [7:0] litByte,
  output logic [7:0] rxHead,
  output logic       txEmpty,
  output logic       txFull,
  output logic       rxEmpty,
  output logic       rxFull,
  output logic       shBusy,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int DIVW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [DIVW-1:0] DIV_END = DIVW'(SCK_HALF - 1);

  logic [7:0]      txHead, txSh, rxSh;
  logic [2:0]      bitCnt;
  logic [DIVW-1:0] divCnt;
  logic            busyR, sckR, capR, rxPush, halfEnd;

  sflash_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .push(cmd.pushTx), .pop(cmd.loadFifo),
    .clear(cmd.flush), .din(txData), .head(txHead),
    .empty(txEmpty), .full(txFull));

  sflash_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .pop(cmd.popRx),
    .clear(cmd.flush), .din(rxSh), .head(rxHead),
    .empty(rxEmpty), .full(rxFull));

  assign halfEnd = busyR && (divCnt == DIV_END);
  // Last falling edge of a captured byte: push in the same edge busy drops.
  assign rxPush  = halfEnd && sckR && (bitCnt == 3'd7) && capR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '0;
      rxSh   <= '0;
      bitCnt <= '0;
      divCnt <= '0;
      busyR  <= 1'b0;
      sckR   <= 1'b0;
      capR   <= 1'b0;
    end else if (cmd.loadLit || cmd.loadFifo) begin
      txSh   <= cmd.loadFifo ? txHead : litByte;
      bitCnt <= '0;
      divCnt <= '0;
      busyR  <= 1'b1;
      sckR   <= 1'b0;
      capR   <= cmd.capture;
    end else if (busyR) begin
      if (halfEnd) begin
        divCnt <= '0;
        if (!sckR) begin
          sckR <= 1'b1;
          rxSh <= {rxSh[6:0], miso};
        end else begin
          sckR   <= 1'b0;
          txSh   <= {txSh[6:0], 1'b0};
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) busyR <= 1'b0;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign shBusy = busyR;
  assign sck    = sckR;
  assign mosi   = txSh[7];

  // R12
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyR |-> !sckR);

endmodule

// File: rtl/sflash_ctl.sv
module sflash_ctl
  import sflash_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regEn,
  input  logic        regWe,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output dpCmd_t      cmd,
  output logic [7:0]  litByte,
  input  logic [7:0]  rxHead,
  input  logic        txEmpty,
  input  logic        txFull,
  input  logic        rxEmpty,
  input  logic        rxFull,
  input  logic        shBusy,
  output logic        csN
);
  seqState_t   state;
  logic        csEn, dirWr, flushPend, stopReq, startBit;
  logic [7:0]  instrR, hdrR;
  logic [31:0] addrR, modeR, dinCntR, dataCnt;
  logic [4:0]  idx, hdrTotal, aPos;
  logic [3:0]  nInstr;
  logic [2:0]  nAddr;
  logic [7:0]  hdrByte;
  logic        wr, rd, confWr, xferRdy, endRead;

  assign wr      = regEn && regWe;
  assign rd      = regEn && !regWe;
  assign confWr  = wr && (regAddr == OFF_CONF);
  assign xferRdy = (state == ST_IDLE) && !flushPend;
  assign endRead = (dinCntR != '0) && (dataCnt == dinCntR);

  // Header layout: instruction copies, then up to three address bytes.
  always_comb begin
    nInstr   = hdrR[3:0];
    nAddr    = (hdrR[7:4] > 4'd3) ? 3'd3 : hdrR[6:4];
    hdrTotal = {1'b0, nInstr} + {2'b0, nAddr};
    aPos     = {2'b0, nAddr} - 5'd1 - (idx - {1'b0, nInstr});
    if (idx < {1'b0, nInstr}) hdrByte = instrR;
    else begin
      case (aPos[1:0])
        2'd0:    hdrByte = addrR[7:0];
        2'd1:    hdrByte = addrR[15:8];
        default: hdrByte = addrR[23:16];
      endcase
    end
  end

  always_comb begin
    cmd          = '0;
    litByte      = 8'h00;
    cmd.pushTx   = wr && (regAddr == OFF_DOUT);
    cmd.popRx    = rd && (regAddr == OFF_DIN);
    cmd.flush    = flushPend;
    if (!shBusy && !flushPend) begin
      if (state == ST_HDR && idx < hdrTotal) begin
        cmd.loadLit = 1'b1;
        litByte     = hdrByte;
      end else if (state == ST_DATA) begin
        if (dirWr) cmd.loadFifo = !txEmpty;
        else if (!endRead && !stopReq && !rxFull) begin
          cmd.loadLit = 1'b1;
          cmd.capture = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      {csEn, dirWr, flushPend, stopReq, startBit} <= '0;
      instrR <= '0; hdrR <= '0; addrR <= '0; modeR <= '0; dinCntR <= '0;
      idx <= '0; dataCnt <= '0;
    end else begin
      flushPend <= confWr && regWdata[9];
      if (wr) begin
        case (regAddr)
          OFF_CTRL:  csEn    <= regWdata[0];
          OFF_INSTR: instrR  <= regWdata[7:0];
          OFF_ADDR:  addrR   <= regWdata;
          OFF_MODE:  modeR   <= regWdata;
          OFF_HDR:   hdrR    <= regWdata[7:0];
          OFF_DCNT:  dinCntR <= regWdata;
          default: ;
        endcase
      end
      case (state)
        ST_IDLE: begin
          if (confWr) dirWr <= regWdata[13];
          if (confWr && regWdata[15] && !flushPend) begin
            state    <= ST_HDR;
            startBit <= 1'b1;
            stopReq  <= 1'b0;
            idx      <= '0;
            dataCnt  <= '0;
          end
        end
        ST_HDR: begin
          if (cmd.loadLit) idx <= idx + 5'd1;
          else if (!shBusy && idx >= hdrTotal) state <= ST_DATA;
        end
        ST_DATA: begin
          if (cmd.loadLit) dataCnt <= dataCnt + 32'd1;
          else if (!shBusy && !cmd.loadFifo) begin
            if (dirWr ? (txEmpty && stopReq) : (stopReq || endRead))
              state <= ST_FIN;
          end
        end
        default: begin
          startBit <= 1'b0;
          stopReq  <= 1'b0;
          state    <= ST_IDLE;
        end
      endcase
      if (confWr && regWdata[14] && state != ST_IDLE && state != ST_FIN)
        stopReq <= 1'b1;
    end
  end

  assign csN = !(csEn && state != ST_IDLE);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFF_CTRL:  regRdata = {24'b0, txFull, txEmpty, 1'b0, rxEmpty, 2'b0, xferRdy, csEn};
      OFF_CONF:  regRdata = {16'b0, startBit, stopReq, dirWr, 3'b0, flushPend, 9'b0};
      OFF_DIN:   regRdata = rxEmpty ? 32'b0 : {24'b0, rxHead};
      OFF_INSTR: regRdata = {24'b0, instrR};
      OFF_ADDR:  regRdata = addrR;
      OFF_MODE:  regRdata = modeR;
      OFF_HDR:   regRdata = {24'b0, hdrR};
      OFF_DCNT:  regRdata = dinCntR;
      default:   regRdata = '0;
    endcase
  end

  // R5
  stop_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBit) |-> (!dirWr || $past(txEmpty)));

  // R12
  shift_in_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    shBusy |-> (state != ST_IDLE));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushPend && !confWr) |=> !flushPend);

  // R11
  rdy_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startBit) |-> (state != ST_IDLE));

endmodule

// File: rtl/sflash_master.sv
module sflash_master
  import sflash_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int SCK_HALF   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regEn,
  input  logic        regWe,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        spiCsN,
  output logic        spiSck,
  output logic        spiMosi,
  input  logic        spiMiso
);
  dpCmd_t     cmd;
  logic [7:0] litByte, rxHead;
  logic       txEmpty, txFull, rxEmpty, rxFull, shBusy;

  sflash_ctl uCtl (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cmd(cmd), .litByte(litByte), .rxHead(rxHead),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty),
    .rxFull(rxFull), .shBusy(shBusy), .csN(spiCsN));

  sflash_dp #(.FIFO_DEPTH(FIFO_DEPTH), .SCK_HALF(SCK_HALF)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txData(regWdata[7:0]),
    .litByte(litByte), .rxHead(rxHead), .txEmpty(txEmpty),
    .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .shBusy(shBusy), .sck(spiSck), .mosi(spiMosi), .miso(spiMiso));

endmodule

// File: tb/sim_sflash_master.sv
module sim_sflash_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regEn = 1'b0, regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        spiCsN, spiSck, spiMosi, spiMiso;

  int tests = 0, fails = 0, monErr = 0;
  bit done = 0, benchCsEn = 0;

  always #10 clk = ~clk;

  sflash_master u0 (.*);

  // Flash model: records MOSI bytes, answers with a known pattern.
  int       sBit = 0;
  logic [7:0] sShift = '0;
  byte      capQ[$];
  byte      expQ[$];

  function automatic logic [7:0] pat(input int i);
    return 8'(8'h3C + i * 17);
  endfunction
  function automatic logic misoBit(input int b);
    logic [7:0] v;
    v = pat(b / 8);
    return v[7 - (b % 8)];
  endfunction

  assign spiMiso = misoBit(sBit);
  always @(negedge spiCsN) sBit = 0;
  always @(posedge spiSck) if (spiCsN === 1'b0) begin
    sShift = {sShift[6:0], spiMosi};
    sBit++;
    if (sBit % 8 == 0) capQ.push_back(sShift);
  end

  // Per-clock reference: chip-select and clock against the enable bit (R12).
  always @(negedge clk) if (rstN) begin
    if (!benchCsEn && spiCsN === 1'b0) monErr++;
    if (benchCsEn && spiSck && spiCsN) monErr++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regEn = 1; regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regEn = 0; regWe = 0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regEn = 1; regWe = 0; regAddr = a;
    #1 d = regRdata;
    @(negedge clk); regEn = 0;
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] v;
    int n;
    n = 0;
    do begin rdReg(8'h04, v); n++; end while (v[15] && n < 3000);
    check({tag, " start bit clears"}, {31'b0, v[15]}, 32'd0);
  endtask

  task automatic cmpCap(input string tag);
    check({tag, " byte count"}, capQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < capQ.size(); i++)
      check(tag, {24'b0, capQ[i]}, {24'b0, expQ[i]});
    capQ.delete();
    expQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rdReg(8'h00, v);
    check("R1 ctrl reset", v, 32'h52);
    check("R1 csN idle", {31'b0, spiCsN}, 32'd1);
    check("R1 sck idle", {31'b0, spiSck}, 32'd0);

    // R2 storage registers
    wrReg(8'h18, 32'h1234_5678); rdReg(8'h18, v); check("R2 read-mode", v, 32'h1234_5678);
    wrReg(8'h20, 32'h0000_0A05); rdReg(8'h20, v); check("R2 data-in-count", v, 32'h0A05);
    wrReg(8'h14, 32'hA1B2_C3D4); rdReg(8'h14, v); check("R2 address", v, 32'hA1B2_C3D4);
    wrReg(8'h1C, 32'h31);        rdReg(8'h1C, v); check("R2 header-count", v, 32'h31);
    wrReg(8'h10, 32'h02);        rdReg(8'h10, v); check("R2 instruction", v, 32'h02);

    // R9 R4 R3 R5: page program with overfilled FIFO
    wrReg(8'h00, 32'h1); benchCsEn = 1;
    for (int i = 0; i < 9; i++) wrReg(8'h08, 32'h50 + i);
    rdReg(8'h00, v); check("R9 full flag", {31'b0, v[7]}, 32'd1);
    wrReg(8'h04, 32'hA000);
    wrReg(8'h04, 32'h6000);
    rdReg(8'h04, v); check("R5 start held while FIFO drains", {31'b0, v[15]}, 32'd1);
    rdReg(8'h00, v); check("R11 not ready while running", {31'b0, v[1]}, 32'd0);
    waitIdle("R5");
    expQ = '{8'h02, 8'hB2, 8'hC3, 8'hD4};
    for (int i = 0; i < 8; i++) expQ.push_back(byte'(8'h50 + i));
    cmpCap("R4 R9 R3 page program stream");
    rdReg(8'h00, v); check("R4 tx empty after", {31'b0, v[6]}, 32'd1);

    // R3 two address bytes; then instruction x2 with clamped address count
    wrReg(8'h10, 32'h9F); wrReg(8'h1C, 32'h21);
    wrReg(8'h04, 32'hA000); wrReg(8'h04, 32'h6000); waitIdle("R3a");
    expQ = '{8'h9F, 8'hC3, 8'hD4}; cmpCap("R3 two address bytes");
    wrReg(8'h1C, 32'h52);
    wrReg(8'h04, 32'hA000); wrReg(8'h04, 32'h6000); waitIdle("R3b");
    expQ = '{8'h9F, 8'h9F, 8'hB2, 8'hC3, 8'hD4}; cmpCap("R3 clamped address");

    // R6 counted read: header 4 bytes, then 3 data bytes
    wrReg(8'h10, 32'h03); wrReg(8'h1C, 32'h31); wrReg(8'h14, 32'h0012_3456);
    wrReg(8'h20, 32'd3);
    wrReg(8'h04, 32'h8000); waitIdle("R6");
    expQ = '{8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00}; cmpCap("R6 R3 read header");
    for (int i = 0; i < 3; i++) begin
      rdReg(8'h0C, v); check("R6 R8 read byte", v, {24'b0, pat(4 + i)});
    end
    rdReg(8'h00, v); check("R6 rx empty after N", {31'b0, v[4]}, 32'd1);
    rdReg(8'h0C, v); check("R8 empty read returns 0", v, 32'd0);

    // R7 continuous read with receive FIFO back-pressure
    wrReg(8'h10, 32'h0B); wrReg(8'h1C, 32'h01); wrReg(8'h20, 32'd0);
    wrReg(8'h04, 32'h8000);
    repeat (800) @(posedge clk);
    rdReg(8'h04, v); check("R7 still running", {31'b0, v[15]}, 32'd1);
    wrReg(8'h04, 32'h4000); waitIdle("R7");
    for (int i = 0; i < 8; i++) begin
      rdReg(8'h0C, v); check("R7 held byte", v, {24'b0, pat(1 + i)});
    end
    rdReg(8'h00, v); check("R7 R8 nothing extra", {31'b0, v[4]}, 32'd1);
    capQ.delete();

    // R10 flush
    for (int i = 0; i < 3; i++) wrReg(8'h08, 32'h77);
    rdReg(8'h00, v); check("R10 tx not empty before", {31'b0, v[6]}, 32'd0);
    @(negedge clk); regEn = 1; regWe = 1; regAddr = 8'h04; regWdata = 32'h0200;
    @(negedge clk); regWe = 0; regAddr = 8'h04;
    #1 check("R10 flush bit reads 1", {31'b0, regRdata[9]}, 32'd1);
    @(negedge clk); regEn = 0;
    rdReg(8'h04, v); check("R10 flush bit self-clears", {31'b0, v[9]}, 32'd0);
    rdReg(8'h00, v); check("R10 both FIFOs empty", {24'b0, v[7:0]} & 32'hD0, 32'h50);

    // R12 chip-select disabled: transfer runs, flash sees nothing
    wrReg(8'h00, 32'h0); benchCsEn = 0;
    wrReg(8'h04, 32'hA000); wrReg(8'h04, 32'h6000); waitIdle("R12");
    check("R12 no bytes with enable off", capQ.size(), 32'd0);
    check("R12 per-clock chip-select monitor", monErr, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule